// File: doc/BRIEF.md
# Banked Byte Memory Read Sequencer

This block lets a synchronous master fetch single bytes from a set of external asynchronous byte-wide memory banks. Each request carries a 15-bit word address and a bank number. The bank number is decoded into one active-low chip enable per bank. A single active-low output enable is shared by every bank and acts as the read strobe. Parameters give the access delay, the output-enable delay and the bus release delay, all counted in clock cycles. The block holds the address and the selected enable for the whole access and captures the byte on the last cycle of the window. It then returns the byte with a one-cycle valid pulse.

When the block is not reading, every chip enable and the output enable stay high, so all devices rest in standby with their outputs floating. A device may keep driving the data lines for a short time after it is released. For that reason, a request to a bank other than the one just read is held off until the release delay has passed. A request to the same bank may start at once.

Top module: `bytemem_rd_ctrl`

## Requirements
- R1: After reset, all bits of `mem_ce_n` are 1, `mem_oe_n` is 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: During an access, exactly one bit of `mem_ce_n` is 0: bit index equal to the accepted `req_bank` value. At all other times no bit is 0.
- R3: During an access, `mem_addr` equals the accepted `req_addr` and does not change while a chip enable is low.
- R4: For each access, the chip enable stays low for exactly ACC_CYC consecutive cycles, starting in the cycle after the request is accepted. It is released in the cycle where `rsp_valid` is 1.
- R5: `mem_oe_n` is 0 only while a chip enable is 0. It is low for the last OE_CYC cycles of the chip-enable window and for no other cycle.
- R6: `rsp_valid` is a single-cycle pulse in the cycle after the last chip-enable cycle, which is ACC_CYC+1 cycles after the accepting edge. `rsp_data` equals the byte on `mem_data_in` during that last chip-enable cycle.
- R7: After a response, a request to a different bank sees `req_ready` low for FLOAT_CYC cycles, counted from the cycle where `rsp_valid` is 1. No other bank's chip enable goes low within FLOAT_CYC cycles of `mem_oe_n` rising.
- R8: After a response, a request to the same bank sees `req_ready` high in the cycle where `rsp_valid` is 1.
- R9: While an access is in progress, `req_ready` is 0. A request presented then changes neither `mem_addr`, `mem_ce_n` nor the returned byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address within the bank |
| req_bank | input | BANK_W | Bank number |
| req_ready | output | 1 | Request is taken at this clock edge when valid |
| rsp_valid | output | 1 | One-cycle pulse with the read byte |
| rsp_data | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Address to the memory banks |
| mem_ce_n | output | 2**BANK_W | Active-low chip enable per bank |
| mem_oe_n | output | 1 | Active-low output enable shared by all banks |
| mem_data_in | input | DATA_W | Data lines from the memory banks |

## Verification
With the accepting edge taken as edge zero, the chip enable of the chosen bank is low in cycles 1 to ACC_CYC. The output enable is low in cycles ACC_CYC-OE_CYC+1 to ACC_CYC. The response pulse falls in cycle ACC_CYC+1. The bench walks these cycles one at a time and samples at the falling edge, so each count and index is compared with that schedule. The memory model in the bench drives a valid byte only after the chip enable has been low for ACC_CYC cycles and the output enable for OE_CYC cycles. A capture that comes early therefore returns a marker byte instead. Stall lengths on bank changes are counted from the response cycle and must equal FLOAT_CYC. For a repeat of the same bank the stall must be zero.

// File: rtl/bytemem_rd_ctrl.sv
module bytemem_rd_ctrl #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int BANK_W    = 2,
  parameter int ACC_CYC   = 6,
  parameter int OE_CYC    = 3,
  parameter int FLOAT_CYC = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [BANK_W-1:0]      req_bank,
  output logic                   req_ready,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_data,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [(1<<BANK_W)-1:0] mem_ce_n,
  output logic                   mem_oe_n,
  input  logic [DATA_W-1:0]      mem_data_in
);
  localparam int NBANK    = 1 << BANK_W;
  localparam int CNT_W    = $clog2(ACC_CYC + 1);
  localparam int FLT_W    = $clog2(FLOAT_CYC + 2);
  localparam int OE_START = ACC_CYC - OE_CYC;

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q, last_bank;
  logic [FLT_W-1:0]  flt_cnt;
  logic              accept, done;

  assign req_ready = !busy && (flt_cnt == '0 || req_bank == last_bank);
  assign accept    = req_valid && req_ready;
  assign done      = busy && cnt == CNT_W'(ACC_CYC - 1);
  assign mem_addr  = addr_q;
  assign mem_oe_n  = !(busy && cnt >= CNT_W'(OE_START));

  for (genvar b = 0; b < NBANK; b++) begin : g_ce
    assign mem_ce_n[b] = !(busy && bank_q == BANK_W'(b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      addr_q    <= '0;
      bank_q    <= '0;
      last_bank <= '0;
      flt_cnt   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (flt_cnt != '0) flt_cnt <= flt_cnt - 1'b1;
      if (accept) begin
        busy   <= 1'b1;
        cnt    <= '0;
        addr_q <= req_addr;
        bank_q <= req_bank;
      end else if (done) begin
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_data  <= mem_data_in;
        last_bank <= bank_q;
        flt_cnt   <= FLT_W'(FLOAT_CYC);
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bytemem_rd_ctrl_chk.sv
module bytemem_rd_ctrl_chk #(
  parameter int ADDR_W    = 15,
  parameter int BANK_W    = 2,
  parameter int FLOAT_CYC = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_ready,
  input logic                   rsp_valid,
  input logic [ADDR_W-1:0]      mem_addr,
  input logic [(1<<BANK_W)-1:0] mem_ce_n,
  input logic                   mem_oe_n
);
  localparam int NBANK = 1 << BANK_W;

  logic              ce_any;
  logic [BANK_W-1:0] sel, drv_bank;
  int                gap;

  assign ce_any = !(&mem_ce_n);

  always_comb begin
    sel = '0;
    for (int i = 0; i < NBANK; i++) if (!mem_ce_n[i]) sel = BANK_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap      <= FLOAT_CYC;
      drv_bank <= '0;
    end else if (!mem_oe_n) begin
      gap      <= 0;
      drv_bank <= sel;
    end else if (gap < FLOAT_CYC) begin
      gap <= gap + 1;
    end
  end

  AST_CE_ONEHOT:     assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~mem_ce_n)); // R2
  AST_ADDR_STABLE:   assert property (@(posedge clk) disable iff (!rst_n) ce_any && $past(ce_any) |-> $stable(mem_addr)); // R3
  AST_RELEASE_RSP:   assert property (@(posedge clk) disable iff (!rst_n) $past(ce_any) && !ce_any |-> rsp_valid); // R4
  AST_OE_NEEDS_CE:   assert property (@(posedge clk) disable iff (!rst_n) !mem_oe_n |-> ce_any); // R5
  AST_RSP_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R6
  AST_FLOAT_GAP:     assert property (@(posedge clk) disable iff (!rst_n) ce_any && gap < FLOAT_CYC |-> sel == drv_bank); // R7
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n) ce_any |-> !req_ready); // R9
endmodule

bind bytemem_rd_ctrl bytemem_rd_ctrl_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .FLOAT_CYC(FLOAT_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n)
);

// File: tb/bytemem_rd_ctrl_tb.sv
`timescale 1ns/1ps
module bytemem_rd_ctrl_tb_top;
  localparam int ADDR_W = 15, DATA_W = 8, BANK_W = 2;
  localparam int ACC = 6, OEC = 3, FLT = 4;
  localparam int NB = 1 << BANK_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [BANK_W-1:0] req_bank = '0;
  logic req_ready, rsp_valid, mem_oe_n;
  logic [DATA_W-1:0] rsp_data, mem_data_in;
  logic [ADDR_W-1:0] mem_addr;
  logic [NB-1:0] mem_ce_n;
  int checks = 0, errors = 0;
  int ce_age = 0, oe_age = 0;

  always #2.5 clk = ~clk;

  bytemem_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
    .ACC_CYC(ACC), .OE_CYC(OEC), .FLOAT_CYC(FLT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_bank(req_bank), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_data_in(mem_data_in));

  function automatic logic [7:0] pat(int bank, logic [ADDR_W-1:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'(bank * 8'h35);
  endfunction

  function automatic int sel_of(logic [NB-1:0] n);
    int s = -1;
    for (int i = 0; i < NB; i++) if (!n[i]) s = i;
    return s;
  endfunction

  always @(posedge clk) begin
    ce_age <= (&mem_ce_n) ? 0 : ce_age + 1;
    oe_age <= mem_oe_n ? 0 : oe_age + 1;
  end

  always_comb begin
    if (!(&mem_ce_n) && !mem_oe_n && ce_age + 1 >= ACC && oe_age + 1 >= OEC)
      mem_data_in = pat(sel_of(mem_ce_n), mem_addr);
    else
      mem_data_in = 8'hEE;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Caller is just after a negedge. Returns in the response cycle.
  task automatic do_read(int bank, logic [ADDR_W-1:0] a, output int waited);
    int ce_lo = 0, oe_lo = 0, oe_first = 0, k = 0;
    bit sel_ok = 1, addr_ok = 1;
    waited = 0;
    req_valid = 1'b1; req_bank = BANK_W'(bank); req_addr = a;
    #1;
    while (!req_ready) begin @(negedge clk); waited++; end
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    while (!rsp_valid && k < 4 * ACC) begin
      if (!(&mem_ce_n)) begin
        ce_lo++;
        if (sel_of(mem_ce_n) != bank || $countones(~mem_ce_n) != 1) sel_ok = 0;
        if (mem_addr != a) addr_ok = 0;
      end
      if (!mem_oe_n) begin
        if (oe_lo == 0) oe_first = k;
        oe_lo++;
      end
      @(negedge clk); k++;
    end
    chk(sel_ok, "R2 chip enable decode", sel_of(mem_ce_n), bank);
    chk(addr_ok, "R3 address held", int'(mem_addr), int'(a));
    chk(ce_lo == ACC, "R4 chip enable cycles", ce_lo, ACC);
    chk(oe_lo == OEC && oe_first == ACC - OEC + 1, "R5 output enable window", oe_first, ACC - OEC + 1);
    chk(rsp_valid && k == ACC + 1, "R6 response latency", k, ACC + 1);
    chk(rsp_data == pat(bank, a), "R6 response data", rsp_data, pat(bank, a));
    chk(&mem_ce_n, "R4 release at response", int'(mem_ce_n), NB - 1);
  endtask

  task automatic t_reset();
    chk(&mem_ce_n, "R1 chip enables idle", int'(mem_ce_n), NB - 1);
    chk(mem_oe_n, "R1 output enable idle", mem_oe_n, 1);
    chk(!rsp_valid, "R1 no response", rsp_valid, 0);
    chk(req_ready, "R1 ready", req_ready, 1);
  endtask

  task automatic t_patterns();
    int w;
    do_read(1, 15'h1234, w);
    @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);
    do_read(0, 15'h0000, w);
    @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);
    do_read(3, 15'h7FFF, w);
    @(negedge clk);
    chk(!rsp_valid, "R6 single pulse", rsp_valid, 0);
  endtask

  task automatic t_same_bank();
    int w;
    do_read(2, 15'h2AAA, w);
    do_read(2, 15'h5555, w);
    chk(w == 0, "R8 same bank no stall", w, 0);
  endtask

  task automatic t_bank_switch();
    int w;
    do_read(3, 15'h0F0F, w);
    do_read(0, 15'h7001, w);
    chk(w == FLT, "R7 bank change stall", w, FLT);
    do_read(1, 15'h0101, w);
    chk(w == FLT, "R7 bank change stall again", w, FLT);
  endtask

  task automatic t_busy_ignore();
    int w;
    bit ok_rdy = 1, ok_addr = 1, ok_ce = 1;
    @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);
    req_valid = 1'b1; req_bank = 2'd0; req_addr = 15'h0ABC;
    #1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_bank = 2'd3; req_addr = 15'h7321;
    for (int k = 1; k <= ACC; k++) begin
      #1;
      if (req_ready) ok_rdy = 0;
      if (mem_addr != 15'h0ABC) ok_addr = 0;
      if (sel_of(mem_ce_n) != 0) ok_ce = 0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(ok_rdy, "R9 not ready while busy", 1, 0);
    chk(ok_addr, "R9 address unchanged", int'(mem_addr), 15'h0ABC);
    chk(ok_ce, "R9 enable unchanged", sel_of(mem_ce_n), 0);
    chk(rsp_valid && rsp_data == pat(0, 15'h0ABC), "R9 original byte returned", rsp_data, pat(0, 15'h0ABC));
    @(negedge clk);
    do_read(0, 15'h0003, w);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    t_patterns();
    @(negedge clk);
    t_same_bank();
    @(negedge clk);
    t_bank_switch();
    t_busy_ignore();
    repeat (8) @(negedge clk);
    summary();
    $finish;
  end
endmodule